// File: doc/BRIEF.md
# SDRAM Armed Special-Command Issuer

This block sits between a processor-style bus and the command pins of an SDRAM. It handles the commands needed to bring an SDRAM out of power-up: precharge-all, auto-refresh and mode-register programming. Software does not write a command code. It sets one of two arm bits and then performs an ordinary read or write into the SDRAM address window. The first such access that hits the window is turned into a single special command. The access is then acknowledged without data, and the arm bit clears itself.

Refresh requests come from an external interval timer as single-cycle ticks. They become refresh commands only while the refresh-enable input is high. The block counts the refreshes it issues, up to eight, and raises a ready flag at eight. Mode programming is held back until that flag is set. After a precharge-all, every command is held off for a programmable number of clocks. For mode programming, the low bus address bits go straight to the SDRAM address pins, with no row/column split, so software chooses the access address to carry the mode word.

Top module: `sdram_special_cmd`

## Requirements
- R1: After reset, the command pins {cs_n,ras_n,cas_n,we_n} read 4'b0111 (NOP), `bus_ack` is low, both arm flags are clear, `ref_count` is 0 and `ref_ready` is low.
- R2: With the precharge arm set, a window-hitting access produces one precharge-all command 4'b0010, with `sd_addr` holding only bit AP_BIT (default bit 10) set. `bus_ack` is high in that same single cycle, and the precharge arm clears.
- R3: After a precharge-all, the pins show NOP for the next `cfg_trp` cycles. A refresh that is already pending is issued exactly `cfg_trp`+1 cycles after the precharge-all cycle.
- R4: A refresh command 4'b0001 is issued only for a `ref_tick` that arrives while `ref_en` is high. A tick that arrives while `ref_en` is low is ignored.
- R5: `ref_count` goes up by one for each refresh issued and stops at 8. `ref_ready` is high exactly when it reads 8.
- R6: With the mode arm set and `ref_ready` high, a window-hitting access, whether a read or a write, produces one mode-register-set command 4'b0000, acknowledged in that cycle, and the mode arm clears. While `ref_ready` is low, the access gets no command and no acknowledge, and the arm stays set.
- R7: During a mode-register-set, `sd_addr` equals bus_addr[SAW-1:0] of the access, unmultiplexed. When nothing blocks it, the command appears in the first cycle after the access is sampled.
- R8: An access whose window bits miss produces no command and no acknowledge, and leaves both arm flags unchanged.
- R9: A window-hitting access with no arm set produces no command and no acknowledge from this block.
- R10: With both arms set, precharge-all fires first and the mode arm stays set for a later access.
- R11: An access hits when (bus_addr[AW-1:WIN_LSB] & ~cfg_mask) == (cfg_base & ~cfg_mask), so any address bits that are set in the mask are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | AW-WIN_LSB (8) | Window base on the upper address bits |
| cfg_mask | input | AW-WIN_LSB (8) | Window don't-care bits |
| cfg_trp | input | TW (4) | Precharge recovery, in clocks |
| arm_pall_set | input | 1 | Pulse that arms a precharge-all |
| arm_mrs_set | input | 1 | Pulse that arms a mode-register-set |
| ref_en | input | 1 | Refresh enable |
| ref_tick | input | 1 | Refresh request from the interval timer |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | Access direction (no effect on special commands) |
| bus_addr | input | AW (24) | Access address |
| bus_ack | output | 1 | One-cycle acknowledge of a special command |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_addr | output | SAW (13) | SDRAM address pins |
| pall_armed | output | 1 | Precharge arm state |
| mrs_armed | output | 1 | Mode arm state |
| ref_count | output | 4 | Refreshes issued, saturating at 8 |
| ref_ready | output | 1 | Eight refreshes done |

## Verification
Some properties are checked on every cycle: the quiet period after each precharge-all, the rule that mode programming happens only after ready, the raw address on the pins during mode programming, refreshes only while enabled, acknowledges only for special commands, the arm clearing, and the mode arm surviving a precharge-all. Other behaviour shows only in the bench scenarios. These are the window decode with masked bits, misses leaving the arms armed, the exact latency of a refresh held back by precharge recovery, the saturation of the counter after ten refreshes, and the fact that direction has no effect on mode programming.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP  = 4'b0111,
    CMD_PALL = 4'b0010,
    CMD_REF  = 4'b0001,
    CMD_MRS  = 4'b0000
  } sd_cmd_e;

  // saturating increment toward a ceiling
  function automatic logic [7:0] sat_inc(input logic [7:0] v, input logic [7:0] top);
    return (v < top) ? v + 8'd1 : top;
  endfunction
endpackage

// File: rtl/sdcmd_window.sv
module sdcmd_window #(
  parameter int WW = 8
) (
  input  logic [WW-1:0] addr_hi,
  input  logic [WW-1:0] base,
  input  logic [WW-1:0] mask,
  output logic          hit
);
  function automatic logic match_f(input logic [WW-1:0] a, input logic [WW-1:0] b,
                                   input logic [WW-1:0] m);
    return (a & ~m) == (b & ~m);
  endfunction

  assign hit = match_f(addr_hi, base, mask);
endmodule

// File: rtl/sdcmd_trp_timer.sv
module sdcmd_trp_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          busy
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/sdcmd_ref_tracker.sv
module sdcmd_ref_tracker #(
  parameter int TARGET = 8,
  localparam int CW = $clog2(TARGET + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_en,
  input  logic          ref_tick,
  input  logic          ref_issue,
  output logic          ref_pend,
  output logic [CW-1:0] count,
  output logic          ready
);
  logic [7:0] next_cnt;

  assign next_cnt = sdcmd_pkg::sat_inc(8'(count), 8'(TARGET));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ref_pend <= 1'b0;
    else if (!ref_en)   ref_pend <= 1'b0;
    else if (ref_tick)  ref_pend <= 1'b1;
    else if (ref_issue) ref_pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count <= '0;
    else if (ref_issue) count <= next_cnt[CW-1:0];
  end

  assign ready = (count == CW'(TARGET));
endmodule

// File: rtl/sdram_special_cmd.sv
module sdram_special_cmd
  import sdcmd_pkg::*;
#(
  parameter int AW         = 24,
  parameter int WIN_LSB    = 16,
  parameter int SAW        = 13,
  parameter int AP_BIT     = 10,
  parameter int TW         = 4,
  parameter int REF_TARGET = 8,
  localparam int WW = AW - WIN_LSB,
  localparam int CW = $clog2(REF_TARGET + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [WW-1:0]  cfg_base,
  input  logic [WW-1:0]  cfg_mask,
  input  logic [TW-1:0]  cfg_trp,
  input  logic           arm_pall_set,
  input  logic           arm_mrs_set,
  input  logic           ref_en,
  input  logic           ref_tick,
  input  logic           bus_req,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  output logic           bus_ack,
  output logic           sd_cs_n,
  output logic           sd_ras_n,
  output logic           sd_cas_n,
  output logic           sd_we_n,
  output logic [SAW-1:0] sd_addr,
  output logic           pall_armed,
  output logic           mrs_armed,
  output logic [CW-1:0]  ref_count,
  output logic           ref_ready
);
  function automatic logic [SAW-1:0] pall_addr_f();
    logic [SAW-1:0] v;
    v = '0;
    v[AP_BIT] = 1'b1;
    return v;
  endfunction

  // named internal events
  logic win_hit, trp_busy, ref_pend;
  logic access_ok, fire_ref, fire_pall, fire_mrs;
  sd_cmd_e cmd_q;

  // direction and the middle address bits play no part here
  logic unused_bits;
  assign unused_bits = ^{bus_we, bus_addr};

  sdcmd_window #(.WW(WW)) u_win (
    .addr_hi (bus_addr[AW-1:WIN_LSB]),
    .base    (cfg_base),
    .mask    (cfg_mask),
    .hit     (win_hit)
  );

  sdcmd_trp_timer #(.TW(TW)) u_trp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fire_pall),
    .load_val (cfg_trp),
    .busy     (trp_busy)
  );

  sdcmd_ref_tracker #(.TARGET(REF_TARGET)) u_ref (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_en    (ref_en),
    .ref_tick  (ref_tick),
    .ref_issue (fire_ref),
    .ref_pend  (ref_pend),
    .count     (ref_count),
    .ready     (ref_ready)
  );

  // refresh wins over a special access; nothing starts during recovery
  assign fire_ref  = ref_pend && ref_en && !trp_busy;
  assign access_ok = bus_req && win_hit && !bus_ack && !trp_busy && !fire_ref;
  assign fire_pall = access_ok && pall_armed;
  assign fire_mrs  = access_ok && !pall_armed && mrs_armed && ref_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pall_armed <= 1'b0;
      mrs_armed  <= 1'b0;
    end else begin
      if (arm_pall_set)   pall_armed <= 1'b1;
      else if (fire_pall) pall_armed <= 1'b0;
      if (arm_mrs_set)    mrs_armed  <= 1'b1;
      else if (fire_mrs)  mrs_armed  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= CMD_NOP;
      sd_addr <= '0;
      bus_ack <= 1'b0;
    end else if (fire_ref) begin
      cmd_q   <= CMD_REF;
      sd_addr <= '0;
      bus_ack <= 1'b0;
    end else if (fire_pall) begin
      cmd_q   <= CMD_PALL;
      sd_addr <= pall_addr_f();
      bus_ack <= 1'b1;
    end else if (fire_mrs) begin
      cmd_q   <= CMD_MRS;
      sd_addr <= bus_addr[SAW-1:0];
      bus_ack <= 1'b1;
    end else begin
      cmd_q   <= CMD_NOP;
      bus_ack <= 1'b0;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
endmodule

// File: rtl/sdcmd_checker.sv
module sdcmd_checker #(
  parameter int AW         = 24,
  parameter int SAW        = 13,
  parameter int TW         = 4,
  parameter int REF_TARGET = 8,
  localparam int CW = $clog2(REF_TARGET + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sd_cs_n,
  input logic           sd_ras_n,
  input logic           sd_cas_n,
  input logic           sd_we_n,
  input logic [SAW-1:0] sd_addr,
  input logic [AW-1:0]  bus_addr,
  input logic           bus_ack,
  input logic [TW-1:0]  cfg_trp,
  input logic           ref_en,
  input logic [CW-1:0]  ref_count,
  input logic           ref_ready,
  input logic           pall_armed,
  input logic           mrs_armed,
  input logic           arm_pall_set,
  input logic           fire_pall,
  input logic           fire_mrs
);
  logic [3:0] cmd;
  logic [TW-1:0] gap_q;
  logic past_ok;

  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      gap_q   <= '0;
    end else begin
      past_ok <= 1'b1;
      if (cmd == 4'b0010)    gap_q <= cfg_trp;
      else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
    end
  end

  AST_TRP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q != '0) |-> (cmd == 4'b0111)); // R3
  AST_ACK_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> (cmd == 4'b0010 || cmd == 4'b0000)); // R2
  AST_PALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cmd == 4'b0010 && !$past(arm_pall_set)) |-> !pall_armed); // R2
  AST_REF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cmd == 4'b0001) |-> $past(ref_en)); // R4
  AST_REF_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ref_count <= CW'(REF_TARGET)); // R5
  AST_MRS_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0000) |-> ref_ready); // R6
  AST_MRS_RAW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cmd == 4'b0000) |-> (sd_addr == $past(bus_addr[SAW-1:0]))); // R7
  AST_PALL_KEEPS_MRS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cmd == 4'b0010 && $past(mrs_armed)) |-> mrs_armed); // R10
  AST_ONE_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
    fire_pall |-> !fire_mrs); // R10
endmodule

bind sdram_special_cmd sdcmd_checker #(
  .AW(AW), .SAW(SAW), .TW(TW), .REF_TARGET(REF_TARGET)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sd_cs_n      (sd_cs_n),
  .sd_ras_n     (sd_ras_n),
  .sd_cas_n     (sd_cas_n),
  .sd_we_n      (sd_we_n),
  .sd_addr      (sd_addr),
  .bus_addr     (bus_addr),
  .bus_ack      (bus_ack),
  .cfg_trp      (cfg_trp),
  .ref_en       (ref_en),
  .ref_count    (ref_count),
  .ref_ready    (ref_ready),
  .pall_armed   (pall_armed),
  .mrs_armed    (mrs_armed),
  .arm_pall_set (arm_pall_set),
  .fire_pall    (fire_pall),
  .fire_mrs     (fire_mrs)
);

// File: tb/tb_sdram_special_cmd.sv
module tb_sdram_special_cmd;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] NOP = 4'b0111, PALL = 4'b0010, REFC = 4'b0001, MRS = 4'b0000;

  typedef struct packed {
    logic        ap;
    logic        am;
    logic [3:0]  nref;
    logic        we;
    logic [23:0] addr;
    logic        ack;
    logic [3:0]  cmd;
    logic [12:0] sa;
    logic        pa;
    logic        ma;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b0, 4'd0,  1'b0, 24'h500000, 1'b0, 4'b0111, 13'h0000, 1'b1, 1'b0, 4'd0},
    '{1'b0, 1'b0, 4'd0,  1'b0, 24'h430000, 1'b1, 4'b0010, 13'h0400, 1'b0, 1'b0, 4'd1},
    '{1'b0, 1'b0, 4'd0,  1'b0, 24'h410000, 1'b0, 4'b0111, 13'h0000, 1'b0, 1'b0, 4'd0},
    '{1'b0, 1'b1, 4'd0,  1'b0, 24'h410000, 1'b0, 4'b0111, 13'h0000, 1'b0, 1'b1, 4'd0},
    '{1'b0, 1'b0, 4'd10, 1'b0, 24'h410032, 1'b1, 4'b0000, 13'h0032, 1'b0, 1'b0, 4'd1},
    '{1'b1, 1'b1, 4'd0,  1'b0, 24'h401234, 1'b1, 4'b0010, 13'h0400, 1'b0, 1'b1, 4'd1},
    '{1'b0, 1'b0, 4'd0,  1'b1, 24'h420022, 1'b1, 4'b0000, 13'h0022, 1'b0, 1'b0, 4'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cfg_base = 8'h40, cfg_mask = 8'h03;
  logic [3:0] cfg_trp = 4'd3;
  logic arm_pall_set = 0, arm_mrs_set = 0, ref_en = 0, ref_tick = 0;
  logic bus_req = 0, bus_we = 0;
  logic [23:0] bus_addr = '0;
  logic bus_ack, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, pall_armed, mrs_armed, ref_ready;
  logic [12:0] sd_addr;
  logic [3:0] ref_count;
  int n_chk = 0, n_fail = 0, seen_ref = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_special_cmd dut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_trp(cfg_trp),
    .arm_pall_set(arm_pall_set), .arm_mrs_set(arm_mrs_set), .ref_en(ref_en), .ref_tick(ref_tick),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_ack(bus_ack),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .pall_armed(pall_armed), .mrs_armed(mrs_armed),
    .ref_count(ref_count), .ref_ready(ref_ready)
  );

  function automatic logic [3:0] pins();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  always @(negedge clk) if (rst_n && pins() == REFC) seen_ref++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic pulse_tick();
    ref_tick = 1; @(negedge clk);
    ref_tick = 0; repeat (3) @(negedge clk);
  endtask

  // holds the request until acknowledged or 12 cycles pass
  task automatic do_access(input logic [23:0] a, input logic w, output logic got,
                           output logic [3:0] c, output logic [12:0] sa, output int lat);
    got = 0; c = NOP; sa = '0; lat = 0;
    bus_addr = a; bus_we = w; bus_req = 1;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (c == NOP && pins() != NOP) c = pins();
      if (bus_ack) begin
        got = 1; c = pins(); sa = sd_addr; lat = i;
        break;
      end
    end
    bus_req = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    summary();
  end

  initial begin
    logic got; logic [3:0] c; logic [12:0] sa; int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pins() == NOP, "R1 pins", pins(), NOP);
    chk(!bus_ack && !pall_armed && !mrs_armed, "R1 ack/arms", {bus_ack, pall_armed, mrs_armed}, 0);
    chk(ref_count == 0 && !ref_ready, "R1 refresh", ref_count, 0);
    rst_n = 1;
    @(negedge clk);
    chk(pins() == NOP, "R1 idle after release", pins(), NOP);

    // R4 tick while disabled is ignored
    pulse_tick();
    chk(seen_ref == 0 && ref_count == 0, "R4 disabled tick", seen_ref, 0);

    for (int v = 0; v < NV; v++) begin
      string tag;
      case (v)
        0: tag = "R8 miss";
        1: tag = "R2/R11 masked hit";
        2: tag = "R9 unarmed";
        3: tag = "R6 not ready";
        4: tag = "R6/R7 read";
        5: tag = "R10 both armed";
        default: tag = "R6/R7 write";
      endcase
      if (VT[v].nref != 0) begin
        ref_en = 1;
        for (int k = 0; k < int'(VT[v].nref); k++) pulse_tick();
        chk(ref_count == 4'd8 && ref_ready, "R5 saturated", ref_count, 8);
      end
      if (VT[v].ap || VT[v].am) begin
        arm_pall_set = VT[v].ap; arm_mrs_set = VT[v].am;
        @(negedge clk);
        arm_pall_set = 0; arm_mrs_set = 0;
      end
      do_access(VT[v].addr, VT[v].we, got, c, sa, lat);
      chk(got == VT[v].ack, tag, got, VT[v].ack);
      chk(c == VT[v].cmd, tag, c, VT[v].cmd);
      if (VT[v].ack) chk(sa == VT[v].sa, tag, sa, VT[v].sa);
      if (VT[v].lat != 0) chk(lat == int'(VT[v].lat), tag, lat, VT[v].lat);
      @(negedge clk);
      chk(!bus_ack, tag, bus_ack, 0);
      chk(pall_armed == VT[v].pa && mrs_armed == VT[v].ma, tag,
          {pall_armed, mrs_armed}, {VT[v].pa, VT[v].ma});
    end
    chk(seen_ref == 10, "R5 refresh count", seen_ref, 10);
    chk(ref_count == 4'd8, "R5 held at 8", ref_count, 8);

    // R3 pending refresh waits out precharge recovery
    arm_pall_set = 1; @(negedge clk); arm_pall_set = 0;
    do_access(24'h410000, 1'b0, got, c, sa, lat);
    chk(got && c == PALL, "R3 precharge", c, PALL);
    ref_tick = 1;
    lat = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      ref_tick = 0;
      if (pins() != NOP) begin
        lat = k;
        chk(pins() == REFC, "R3 first command", pins(), REFC);
        break;
      end
    end
    chk(lat == int'(cfg_trp) + 1, "R3 gap", lat, int'(cfg_trp) + 1);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule